// File: doc/BRIEF.md
# Oversampled Type B Character Receiver

This block recovers reader-to-card frames of the 106 kbit/s Type B proximity scheme from a demodulated one-bit sample stream. The stream carries four samples per bit period. A sample is taken only in a clock cycle where the sample strobe is high, so the block can run from any system clock faster than the sample rate. The bit value is always read from the third sample of each bit period, which lies mid-bit.

A frame opens with a long low period (start-of-frame). It is checked by counting mid-bit low samples until the line rises. After that comes a series of ten-bit characters: a low start bit, eight data bits sent least significant first, and a high stop bit. High idle time between characters is limited by a timeout. A character that is zero in all ten bits closes the frame. Each accepted byte goes out through a simple write port, with an address equal to its position in the frame. A one-cycle done pulse reports the byte count of a frame that closed correctly.

An in-frame status output lets an arbiter that shares the sample stream tell when a frame is in progress. A synchronous clear input lets the arbiter drop the receiver back to the unsynchronised state when another receiver owns the medium. CRC checking and command decoding are left to the consumer of the byte stream.

Top module: `typeb_char_rx`

## Requirements
- R1: From the unsynchronised state, a low sample starts a start-of-frame check. With four samples per bit, the check counts mid-bit samples (third sample of each bit) that are low. Start-of-frame is accepted when a high mid-bit sample arrives after at least SOF_MIN_BITS (default 10) low bits. With fewer low bits, the block returns to unsynchronised.
- R2: If the low count exceeds SOF_MAX_BITS (default 12) before the line rises, the frame attempt is abandoned. With exactly 12 low bits the start-of-frame is still accepted.
- R3: While a start bit is awaited, more than GAP_MAX (default 25) consecutive high samples return the block to unsynchronised. 25 high samples are tolerated.
- R4: A character is 10 mid-bit samples, shifted into the top of a register that shifts right. It is a data byte when the first bit received is 0 and the last is 1. The byte is made of the eight middle bits, with the first of them as the least significant bit.
- R5: Each data byte is presented for one clock with wr_en high. wr_addr gives the byte's position in the frame, counting from 0.
- R6: A character whose ten bits are all 0 ends the frame. If at least one byte was received, frame_done pulses for exactly one clock and frame_len carries the byte count during that clock. With zero bytes, no pulse is produced.
- R7: Any other character pattern (for example, a stop bit of 0 with nonzero data) is an error. The frame is dropped without a done pulse, and the bytes already written stay written.
- R8: When the byte count reaches MAX_BYTES (default 16), the frame is abandoned as an overflow and gives no done pulse. A frame of MAX_BYTES-1 bytes completes normally.
- R9: in_frame is high from the cycle after start-of-frame acceptance until the frame ends or is abandoned.
- R10: In cycles where sample_stb is low, sample_bit has no effect on state or outputs.
- R11: sync_clr high returns the block to unsynchronised on the next clock. That cycle gives no write and no done pulse.
- R12: After reset, wr_en, frame_done and in_frame are 0, and frame_len is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_clr | input | 1 | Synchronous return to unsynchronised |
| sample_stb | input | 1 | Qualifies sample_bit for this cycle |
| sample_bit | input | 1 | Demodulated line sample |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | $clog2(MAX_BYTES) | Byte position within frame |
| wr_data | output | 8 | Received byte |
| frame_done | output | 1 | One-cycle pulse on a correctly closed frame |
| frame_len | output | $clog2(MAX_BYTES+1) | Byte count, valid with frame_done |
| in_frame | output | 1 | Frame in progress |

## Verification
The hardest cases to reach are the exact edges of the timing windows. These are 12 versus 13 low start-of-frame bits, and 25 versus 26 idle high samples between characters. Each depends on precise sample phase alignment, not on bit values. The stimulus table therefore builds every frame from whole four-sample bits, sets the low-bit count and the idle sample count per row, and places the rows on both sides of each limit. Overflow is reached with one row that carries exactly MAX_BYTES bytes and another that carries one byte fewer. Between strobes, the bench drives the inverted sample value, so any sensitivity to unqualified cycles would corrupt every frame.

// File: rtl/typeb_char_rx.sv
module typeb_char_rx #(
  parameter int SPB          = 4,
  parameter int MID          = 2,
  parameter int SOF_MIN_BITS = 10,
  parameter int SOF_MAX_BITS = 12,
  parameter int GAP_MAX      = 25,
  parameter int MAX_BYTES    = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sync_clr,
  input  logic                           sample_stb,
  input  logic                           sample_bit,
  output logic                           wr_en,
  output logic [$clog2(MAX_BYTES)-1:0]   wr_addr,
  output logic [7:0]                     wr_data,
  output logic                           frame_done,
  output logic [$clog2(MAX_BYTES+1)-1:0] frame_len,
  output logic                           in_frame
);
  localparam int CMAX = (GAP_MAX > SPB) ? GAP_MAX : SPB;
  localparam int CW   = $clog2(CMAX + 2);
  localparam int BMAX = (SOF_MAX_BITS > 10) ? SOF_MAX_BITS : 10;
  localparam int BW   = $clog2(BMAX + 2);
  localparam int LW   = $clog2(MAX_BYTES + 1);
  localparam int AW   = $clog2(MAX_BYTES);
  localparam logic [CW-1:0] MID_C  = CW'(MID);
  localparam logic [CW-1:0] SPB_C  = CW'(SPB);
  localparam logic [CW-1:0] GAP_C  = CW'(GAP_MAX);
  localparam logic [BW-1:0] SMIN_C = BW'(SOF_MIN_BITS);
  localparam logic [BW-1:0] SMAX_C = BW'(SOF_MAX_BITS);
  localparam logic [BW-1:0] CHR_C  = BW'(10);
  localparam logic [LW-1:0] MAXB_C = LW'(MAX_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_SOFL, S_WAIT, S_DATA} st_t;

  st_t           st, st_n;
  logic [CW-1:0] pos, pos_n;
  logic [BW-1:0] bits, bits_n;
  logic [9:0]    sh, sh_n;
  logic [LW-1:0] cnt, cnt_n;
  logic          we_n, done_n;

  assign in_frame = (st == S_WAIT) || (st == S_DATA);

  always_comb begin
    st_n   = st;
    pos_n  = pos;
    bits_n = bits;
    sh_n   = sh;
    cnt_n  = cnt;
    we_n   = 1'b0;
    done_n = 1'b0;
    if (sample_stb) begin
      case (st)
        S_IDLE: if (!sample_bit) begin
          st_n   = S_SOFL;
          pos_n  = '0;
          bits_n = '0;
        end
        S_SOFL: begin
          pos_n = pos + CW'(1);
          if (pos_n == MID_C) begin
            if (sample_bit) begin
              if (bits >= SMIN_C) begin
                st_n  = S_WAIT;
                cnt_n = '0;
              end else begin
                st_n = S_IDLE;
              end
            end else begin
              bits_n = bits + BW'(1);
            end
          end
          if (pos_n >= SPB_C) pos_n = '0;
          if (st_n == S_WAIT) pos_n = '0;
          if (bits_n > SMAX_C) st_n = S_IDLE;
        end
        S_WAIT: begin
          if (sample_bit) begin
            pos_n = pos + CW'(1);
            if (pos_n > GAP_C) st_n = S_IDLE;
          end else begin
            st_n   = S_DATA;
            pos_n  = '0;
            bits_n = '0;
            sh_n   = '0;
          end
        end
        S_DATA: begin
          pos_n = pos + CW'(1);
          if (pos_n == MID_C) begin
            sh_n   = {sample_bit, sh[9:1]};
            bits_n = bits + BW'(1);
            if (bits_n == CHR_C) begin
              if (sh_n[9] && !sh_n[0]) begin
                we_n  = 1'b1;
                cnt_n = cnt + LW'(1);
                st_n  = (cnt_n >= MAXB_C) ? S_IDLE : S_WAIT;
                pos_n = '0;
              end else if (sh_n == 10'd0) begin
                st_n   = S_IDLE;
                done_n = (cnt != '0);
              end else begin
                st_n = S_IDLE;
              end
            end
          end
          if (pos_n >= SPB_C) pos_n = '0;
        end
        default: st_n = S_IDLE;
      endcase
    end
    if (sync_clr) begin
      st_n   = S_IDLE;
      we_n   = 1'b0;
      done_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pos        <= '0;
      bits       <= '0;
      sh         <= '0;
      cnt        <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      frame_done <= 1'b0;
      frame_len  <= '0;
    end else begin
      st         <= st_n;
      pos        <= pos_n;
      bits       <= bits_n;
      sh         <= sh_n;
      cnt        <= cnt_n;
      wr_en      <= we_n;
      frame_done <= done_n;
      if (we_n) begin
        wr_addr <= cnt[AW-1:0];
        wr_data <= sh_n[8:1];
      end
      if (done_n) frame_len <= cnt;
    end
  end

  p_sof_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SOFL) |-> (bits <= SMAX_C));
  p_gap_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (pos <= GAP_C));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  p_done_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_len != '0) && !in_frame);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_len < MAXB_C));
  p_strobe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_stb && !sync_clr) |=> $stable(st) && !wr_en && !frame_done);
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> !in_frame && !wr_en && !frame_done);
endmodule

// File: tb/sim_typeb_char_rx.sv
module sim_typeb_char_rx;
  localparam int MAXB = 16;
  logic clk = 1'b0, rst_n = 1'b0, sync_clr = 1'b0, sample_stb = 1'b0, sample_bit = 1'b1;
  logic wr_en, frame_done, in_frame;
  logic [$clog2(MAXB)-1:0]   wr_addr;
  logic [7:0]                wr_data;
  logic [$clog2(MAXB+1)-1:0] frame_len;

  always #5 clk = ~clk;

  typeb_char_rx #(.MAX_BYTES(MAXB)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .sample_stb(sample_stb),
    .sample_bit(sample_bit), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_done(frame_done), .frame_len(frame_len), .in_frame(in_frame));

  // {sof_bits, nbytes, seed, gap, end_kind, exp_done, exp_len, exp_writes}
  localparam logic [55:0] VEC [0:10] = '{
    {8'd10, 8'd3,  8'h11, 8'd2,  4'd0, 4'd1, 8'd3,  8'd3},
    {8'd12, 8'd1,  8'hA5, 8'd0,  4'd0, 4'd1, 8'd1,  8'd1},
    {8'd11, 8'd4,  8'h3C, 8'd24, 4'd0, 4'd1, 8'd4,  8'd4},
    {8'd9,  8'd2,  8'h11, 8'd2,  4'd0, 4'd0, 8'd0,  8'd0},
    {8'd13, 8'd2,  8'h11, 8'd2,  4'd0, 4'd0, 8'd0,  8'd0},
    {8'd10, 8'd2,  8'h22, 8'd25, 4'd0, 4'd0, 8'd0,  8'd0},
    {8'd10, 8'd0,  8'h00, 8'd2,  4'd0, 4'd0, 8'd0,  8'd0},
    {8'd10, 8'd3,  8'h5A, 8'd3,  4'd1, 4'd0, 8'd0,  8'd3},
    {8'd10, 8'd15, 8'h07, 8'd1,  4'd0, 4'd1, 8'd15, 8'd15},
    {8'd10, 8'd16, 8'h07, 8'd1,  4'd0, 4'd0, 8'd0,  8'd16},
    {8'd10, 8'd2,  8'h00, 8'd0,  4'd0, 4'd1, 8'd2,  8'd2}
  };

  int checks = 0, fails = 0;
  int wr_total = 0, done_total = 0, last_len = 0;
  logic prev_done = 1'b0;
  logic [7:0] cap [0:31];
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (wr_en) begin
      cap[wr_addr] = wr_data;
      wr_total = wr_total + 1;
    end
    if (frame_done) begin
      done_total = done_total + 1;
      last_len = int'(frame_len);
    end
    if (frame_done && prev_done) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL R6 done pulse width: actual 2+ cycles expected 1");
    end
    prev_done = frame_done;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic smp(input logic b);
    @(negedge clk); sample_stb = 1'b1; sample_bit = b;
    @(negedge clk); sample_stb = 1'b0; sample_bit = ~b;
  endtask

  task automatic bitx(input logic b);
    repeat (4) smp(b);
  endtask

  task automatic chr(input logic [9:0] c);
    for (int i = 0; i < 10; i++) bitx(c[i]);
  endtask

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int k);
    return seed + 8'(k * 29);
  endfunction

  initial begin
    #1500000;
    if (!finished) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 wr_en", int'(wr_en), 0);
    chk("R12 frame_done", int'(frame_done), 0);
    chk("R12 in_frame", int'(in_frame), 0);
    chk("R12 frame_len", int'(frame_len), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 11; v++) begin
      automatic logic [55:0] t = VEC[v];
      automatic int sof = int'(t[55:48]);
      automatic int nb = int'(t[47:40]);
      automatic logic [7:0] seed = t[39:32];
      automatic int gap = int'(t[31:24]);
      automatic int endk = int'(t[23:20]);
      automatic int expd = int'(t[19:16]);
      automatic int expl = int'(t[15:8]);
      automatic int expw = int'(t[7:0]);
      automatic int wb = wr_total;
      automatic int db = done_total;
      automatic int bad = 0;
      repeat (8) smp(1'b1);
      repeat (sof) bitx(1'b0);
      bitx(1'b1);
      for (int k = 0; k < nb; k++) begin
        repeat (gap) smp(1'b1);
        chr({1'b1, dbyte(seed, k), 1'b0});
      end
      repeat (gap) smp(1'b1);
      chr(endk == 0 ? 10'h000 : {1'b0, 8'h55, 1'b0});
      repeat (40) smp(1'b1);
      // R1 R2 R3 R6 R7 R8: frame accepted or rejected
      chk($sformatf("R1 R2 R3 R6 R7 R8 done count vec %0d", v), done_total - db, expd);
      if (expd != 0) chk($sformatf("R6 frame_len vec %0d", v), last_len, expl);
      // R5: one write per byte
      chk($sformatf("R5 R7 R8 write count vec %0d", v), wr_total - wb, expw);
      for (int k = 0; k < expw; k++)
        if (cap[k] !== dbyte(seed, k)) bad = bad + 1;
      chk($sformatf("R4 R5 byte content vec %0d", v), bad, 0);
    end

    // R9 R10: status across strobe-free cycles
    repeat (8) smp(1'b1);
    repeat (10) bitx(1'b0);
    bitx(1'b1);
    chk("R9 in_frame after SOF", int'(in_frame), 1);
    begin
      automatic int db = done_total;
      automatic int wb = wr_total;
      @(negedge clk); sample_stb = 1'b0; sample_bit = 1'b0;
      repeat (60) @(negedge clk);
      sample_bit = 1'b1;
      chk("R10 in_frame held without strobe", int'(in_frame), 1);
      chk("R10 no write without strobe", wr_total - wb, 0);
      chr({1'b1, 8'h3C, 1'b0});
      smp(1'b1);
      chr(10'h000);
      repeat (4) smp(1'b1);
      chk("R10 frame completes", done_total - db, 1);
      chk("R10 frame_len", last_len, 1);
      chk("R10 byte", int'(cap[0]), 8'h3C);
      chk("R9 in_frame after EOF", int'(in_frame), 0);
    end

    // R11: synchronous clear mid-frame
    repeat (8) smp(1'b1);
    repeat (10) bitx(1'b0);
    bitx(1'b1);
    chr({1'b1, 8'h81, 1'b0});
    begin
      automatic int db = done_total;
      @(negedge clk); sync_clr = 1'b1;
      @(negedge clk); sync_clr = 1'b0;
      chk("R11 in_frame after clear", int'(in_frame), 0);
      chr({1'b1, 8'hFF, 1'b0});
      smp(1'b1);
      chr(10'h000);
      repeat (40) smp(1'b1);
      chk("R11 no done after clear", done_total - db, 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule